// File: doc/BRIEF.md
# Byte-wise Position-to-DAC Transfer Sequencer

This block copies a 16-bit position count from a quadrature decoder/counter into a 16-bit DAC without a processor. The counter presents its value one byte at a time on an 8-bit output. The DAC has separate high-byte and low-byte input registers. Its load control is tied active, so the analog output follows each byte as it is written.

A three-bit phase counter runs freely on the same clock that drives the position counter, giving a repeating cycle of eight phases. Each phase decodes to a fixed set of control levels:

| Phase | Action |
|-------|--------|
| 0 | Hold the counter output (inhibit) and select the high byte |
| 1 | Strobe the high byte into the DAC |
| 2 | End the high-byte strobe |
| 3 | Select the low byte |
| 4 | Strobe the low byte into the DAC |
| 5 | End the low-byte strobe |
| 6 | Release the inhibit |
| 7 | Idle, or pulse the counter reset if the build enables it |

The DAC therefore receives a fresh 16-bit value once every eight clock periods. All control outputs are registered, so they change only on clock edges and carry no decode glitches.

Top module: `byte_xfer_seq`

## Requirements
- R1: While `rstN` is low, and at once when it falls, the outputs take their phase-0 levels: `inhibitN`=0, `byteSel`=0, `dacHiEnN`=1, `dacLoEnN`=1, `cntRstN`=1 and `dacData`=0. The first clock edge after release enters phase 1.
- R2: The phase advances by one on every clock edge and wraps from 7 to 0, so the output pattern repeats every 8 cycles with no idle gap.
- R3: `byteSel`=0 (high byte) in phases 0, 1, 2, 6 and 7. `dacHiEnN` is low only in phase 1, and only while `byteSel`=0 and `inhibitN`=0.
- R4: `byteSel`=1 (low byte) in phases 3, 4 and 5. `dacLoEnN` is low only in phase 4, and only while `byteSel`=1 and `inhibitN`=0.
- R5: The two DAC enables are never low together. Each enable is low for exactly one cycle. `byteSel` changes only when both enables were high in the cycle before and stay high in the cycle of the change.
- R6: `inhibitN` is 0 in phases 0 to 5 and 1 in phases 6 and 7.
- R7: With parameter CLR_EN=0, `cntRstN` stays 1. With CLR_EN=1, `cntRstN` is 0 only in phase 7, and only while `inhibitN`=1.
- R8: `dacData` is the byte on `cntData` sampled at the end of phase 0, held through phases 1 to 3. It is then the byte sampled at the end of phase 3, held through phases 4 to 0. It does not change across the edge that ends an enable pulse.
- R9: A position value that is stable from phase 7 of one cycle until the end of phase 3 of the next cycle is fully written into the DAC by the end of that next cycle: the high byte and the low byte both land.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Main clock, shared with the position counter |
| rstN | input | 1 | Asynchronous active-low reset |
| cntData | input | 8 | Byte bus from the position counter |
| byteSel | output | 1 | Counter byte select (0 = high byte, 1 = low byte) |
| inhibitN | output | 1 | Active-low hold of the counter output |
| cntRstN | output | 1 | Active-low counter reset |
| dacHiEnN | output | 1 | Active-low DAC high-byte register enable |
| dacLoEnN | output | 1 | Active-low DAC low-byte register enable |
| dacData | output | 8 | Byte presented to the DAC data inputs |

## Verification
The hardest situation to bring about from the ports is a reset that lands in the middle of a transfer, after the high byte is written but before the low byte. Here the outputs must drop straight back to their phase-0 levels without waiting for a clock, and the next cycle must still deliver a complete value.

The bench reaches this state by counting falling edges to phase 4 and pulling reset there. It then checks that the following full cycle lands an entirely new position in its DAC model.

Across hundreds of cycles, the position value changes during the idle phase. This shows that no byte from an earlier value leaks into a later write. A second instance built with the counter-reset option confirms that the reset pulse appears only in phase 7.

// File: rtl/xfer_pkg.sv
`timescale 1ns/1ps
package xfer_pkg;
  localparam int PHASE_W = 3;
  typedef logic [PHASE_W-1:0] phase_t;

  localparam phase_t PH_HI_SETUP = 3'd0;
  localparam phase_t PH_HI_LOAD  = 3'd1;
  localparam phase_t PH_HI_DONE  = 3'd2;
  localparam phase_t PH_LO_SETUP = 3'd3;
  localparam phase_t PH_LO_LOAD  = 3'd4;
  localparam phase_t PH_LO_DONE  = 3'd5;
  localparam phase_t PH_RELEASE  = 3'd6;
  localparam phase_t PH_IDLE     = 3'd7;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;
    logic loadActive;
  } strobe_t;

  // registered control levels
  typedef struct packed {
    logic byteSel;
    logic inhibitN;
    logic cntRstN;
    logic hiEnN;
    logic loEnN;
    logic capture;
  } ctl_t;
endpackage

// File: rtl/xfer_ctrl.sv
`timescale 1ns/1ps
module xfer_ctrl
  import xfer_pkg::*;
#(
  parameter bit CLR_EN = 1'b0
) (
  input  logic    clk,
  input  logic    rstN,
  output logic    byteSel,
  output logic    inhibitN,
  output logic    cntRstN,
  output logic    hiEnN,
  output logic    loEnN,
  output strobe_t strb
);

  phase_t phase;
  phase_t nextPhase;
  ctl_t   ctlQ;

  function automatic ctl_t decode(input phase_t p);
    ctl_t d;
    d.byteSel  = (p == PH_LO_SETUP) || (p == PH_LO_LOAD) || (p == PH_LO_DONE);
    d.inhibitN = (p == PH_RELEASE) || (p == PH_IDLE);
    d.cntRstN  = !(CLR_EN && (p == PH_IDLE));
    d.hiEnN    = (p != PH_HI_LOAD);
    d.loEnN    = (p != PH_LO_LOAD);
    d.capture  = (p == PH_HI_SETUP) || (p == PH_LO_SETUP);
    return d;
  endfunction

  assign nextPhase = phase + 1'b1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase <= PH_HI_SETUP;
      ctlQ  <= decode(PH_HI_SETUP);
    end else begin
      phase <= nextPhase;
      ctlQ  <= decode(nextPhase);
    end
  end

  assign byteSel         = ctlQ.byteSel;
  assign inhibitN        = ctlQ.inhibitN;
  assign cntRstN         = ctlQ.cntRstN;
  assign hiEnN           = ctlQ.hiEnN;
  assign loEnN           = ctlQ.loEnN;
  assign strb.capture    = ctlQ.capture;
  assign strb.loadActive = !ctlQ.hiEnN || !ctlQ.loEnN;

  AST_EN_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(!hiEnN && !loEnN)); // R5
  AST_HI_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    !hiEnN |=> hiEnN); // R5
  AST_LO_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    !loEnN |=> loEnN); // R5
  AST_SEL_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(byteSel) |-> (hiEnN && loEnN && $past(hiEnN) && $past(loEnN))); // R5
  AST_HI_SEL: assert property (@(posedge clk) disable iff (!rstN)
    !hiEnN |-> (!byteSel && !inhibitN)); // R3
  AST_LO_SEL: assert property (@(posedge clk) disable iff (!rstN)
    !loEnN |-> (byteSel && !inhibitN)); // R4
  AST_RST_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !cntRstN |-> inhibitN); // R7
endmodule

// File: rtl/xfer_path.sv
`timescale 1ns/1ps
module xfer_path
  import xfer_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [DATA_W-1:0] cntData,
  output logic [DATA_W-1:0] dacData
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      dacData <= '0;
    else if (strb.capture)
      dacData <= cntData;
  end

  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadActive |=> $stable(dacData)); // R8
  AST_NO_CAPTURE_IN_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadActive |-> !strb.capture); // R8
endmodule

// File: rtl/byte_xfer_seq.sv
`timescale 1ns/1ps
module byte_xfer_seq
  import xfer_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter bit CLR_EN = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] cntData,
  output logic              byteSel,
  output logic              inhibitN,
  output logic              cntRstN,
  output logic              dacHiEnN,
  output logic              dacLoEnN,
  output logic [DATA_W-1:0] dacData
);

  strobe_t strb;

  xfer_ctrl #(.CLR_EN(CLR_EN)) ctrlInst (
    .clk(clk), .rstN(rstN), .byteSel(byteSel), .inhibitN(inhibitN),
    .cntRstN(cntRstN), .hiEnN(dacHiEnN), .loEnN(dacLoEnN), .strb(strb)
  );

  xfer_path #(.DATA_W(DATA_W)) pathInst (
    .clk(clk), .rstN(rstN), .strb(strb), .cntData(cntData), .dacData(dacData)
  );
endmodule

// File: tb/byte_xfer_seq_test.sv
`timescale 1ns/1ps
module byte_xfer_seq_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [15:0] pos;
  logic [15:0] dacReg;
  logic [7:0] cntData;
  logic byteSel, inhibitN, cntRstN, dacHiEnN, dacLoEnN;
  logic [7:0] dacData;
  logic selC, inhC, rstC, hiC, loC;
  logic [7:0] dataC;
  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  assign cntData = byteSel ? pos[7:0] : pos[15:8];

  byte_xfer_seq #(.DATA_W(8), .CLR_EN(1'b0)) uut (
    .clk(clk), .rstN(rstN), .cntData(cntData), .byteSel(byteSel),
    .inhibitN(inhibitN), .cntRstN(cntRstN), .dacHiEnN(dacHiEnN),
    .dacLoEnN(dacLoEnN), .dacData(dacData));

  byte_xfer_seq #(.DATA_W(8), .CLR_EN(1'b1)) uutClr (
    .clk(clk), .rstN(rstN), .cntData(cntData), .byteSel(selC),
    .inhibitN(inhC), .cntRstN(rstC), .dacHiEnN(hiC),
    .dacLoEnN(loC), .dacData(dataC));

  // DAC model: each register latches on the rising edge of its enable
  always @(posedge dacHiEnN) if (rstN) dacReg[15:8] = dacData;
  always @(posedge dacLoEnN) if (rstN) dacReg[7:0]  = dacData;

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic chkReset();
    chk("R1 inhibitN", {15'd0, inhibitN}, 16'd0);
    chk("R1 byteSel", {15'd0, byteSel}, 16'd0);
    chk("R1 dacHiEnN", {15'd0, dacHiEnN}, 16'd1);
    chk("R1 dacLoEnN", {15'd0, dacLoEnN}, 16'd1);
    chk("R1 cntRstN", {15'd0, cntRstN}, 16'd1);
    chk("R1 dacData", {8'd0, dacData}, 16'd0);
  endtask

  // Starts at a falling edge in phase 0; runs n full cycles.
  task automatic doCycles(input int n, input int seed);
    for (int c = 0; c < n; c++) begin
      for (int ph = 0; ph < 8; ph++) begin
        #1;
        chk("R3/R4 byteSel", {15'd0, byteSel}, {15'd0, (ph >= 3 && ph <= 5)});
        chk("R3 dacHiEnN", {15'd0, dacHiEnN}, {15'd0, ph != 1});
        chk("R4 dacLoEnN", {15'd0, dacLoEnN}, {15'd0, ph != 4});
        chk("R6 inhibitN", {15'd0, inhibitN}, {15'd0, ph >= 6});
        chk("R7 cntRstN off", {15'd0, cntRstN}, 16'd1);
        chk("R7 cntRstN on", {15'd0, rstC}, {15'd0, ph != 7});
        chk("R2 sel clr inst", {15'd0, selC}, {15'd0, (ph >= 3 && ph <= 5)});
        if (ph >= 1 && ph <= 3) chk("R8 high byte", {8'd0, dacData}, {8'd0, pos[15:8]});
        if (ph >= 4)            chk("R8 low byte", {8'd0, dacData}, {8'd0, pos[7:0]});
        if (ph == 7) begin
          chk("R9 dac value", dacReg, pos);
          pos = 16'((seed + c) * 40503) ^ 16'(c << 5);
        end
        @(negedge clk);
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    pos = 16'hFFFF;
    dacReg = 16'h0;
    repeat (3) @(negedge clk);
    #1 chkReset();
    @(negedge clk);
    rstN = 1'b1;
    // corner patterns, one cycle each
    doCycles(1, 0);
    pos = 16'h0000; doCycles(1, 0);
    pos = 16'hFF00; doCycles(1, 0);
    pos = 16'h00FF; doCycles(1, 0);
    pos = 16'h8001; doCycles(1, 0);
    pos = 16'h5AA5; doCycles(1, 0);
    // sweep
    doCycles(256, 7);
    // reset in phase 4: high byte written, low byte not yet
    repeat (4) @(negedge clk);
    rstN = 1'b0;
    #1 chkReset();
    pos = 16'hC3E1;
    @(negedge clk);
    rstN = 1'b1;
    doCycles(2, 99);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule